// File: doc/BRIEF.md
# Two-Register Accumulating Binary Adder

This block sums a stream of unsigned binary operands. It has two word registers. The operand register takes a value from the data input when the load strobe is high at a clock edge. The accumulator register holds the running total. A ripple chain of full adders forms the sum of the two registers at all times. The carry into the lowest bit is fixed at zero.

The sum reaches the accumulator only on an edge where the transfer strobe is high. The carry out of the top full adder is stored at the same edge. Adding one operand therefore takes two steps: load the operand, then transfer the sum. A clear strobe sets the accumulator and the carry flag to zero, which starts a new total.

The word width is set by the parameter `N`, with a default of 4 bits. All state resets asynchronously through an active-low reset.

Top module: `acc_adder_core`

## Requirements
- R1: While `rst_ni` is low, `acc_o` and `carry_o` are zero and the operand register is zero. So the first transfer after reset, with no load before it, leaves `acc_o` at its old value plus 0.
- R2: A clock edge with `clear_i` high sets `acc_o` to 0 and `carry_o` to 0.
- R3: A clock edge with `load_i` high copies `data_i` into the operand register. If `clear_i` and `transfer_i` are low at that edge, `acc_o` and `carry_o` do not change.
- R4: A clock edge with `transfer_i` high and `clear_i` low sets `acc_o` to (`acc_o` + operand) mod 2^N. Both values are the ones from before the edge.
- R5: At that same edge, `carry_o` takes bit N of the (N+1)-bit sum, which is the carry out of the most significant full adder.
- R6: On an edge where `clear_i` and `transfer_i` are both low, `acc_o` and `carry_o` keep their values.
- R7: If `clear_i` and `transfer_i` are high at the same edge, clear wins and the result is 0 with the carry at 0.
- R8: If `load_i` and `transfer_i` are high at the same edge, the sum uses the operand from before the edge, and the operand register takes the new `data_i`.
- R9: The sequence clear, load 4'b1001, transfer gives `acc_o` = 4'b1001. A following load 4'b0101 and transfer give 4'b1110 with `carry_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Sets the accumulator and the carry flag to zero |
| load_i | input | 1 | Copies `data_i` into the operand register |
| transfer_i | input | 1 | Writes the adder sum and its carry into the accumulator |
| data_i | input | N | Operand word |
| acc_o | output | N | Accumulator register |
| carry_o | output | 1 | Carry out stored at the last transfer |

## Verification
The assertions assume that the strobes and `data_i` are stable at each rising edge. They also assume that reset is applied before the first edge, so the operand copy kept by the checker starts at zero, the same as the design. The bench changes every input on the falling edge and holds reset low from time zero. It drives every combination of the strobes, including clear with transfer and load with transfer. Its random phase keeps each input within these limits and runs many transfers that overflow the word.

// File: rtl/acc_adder_pkg.sv
package acc_adder_pkg;

  typedef struct packed {
    logic clr;
    logic load;
    logic xfer;
  } strobe_t;

endpackage

// File: rtl/acc_full_adder.sv
module acc_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  logic p;

  // propagate stage, then combine with incoming carry
  assign p   = a_i ^ b_i;
  assign s_o = p ^ c_i;
  assign c_o = (a_i & b_i) | (p & c_i);

endmodule

// File: rtl/acc_ripple_adder.sv
module acc_ripple_adder #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] sum_o,
  output logic         co_o
);

  logic [N:0] c;

  assign c[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_fa
    acc_full_adder u_fa (
      .a_i (a_i[i]),
      .b_i (b_i[i]),
      .c_i (c[i]),
      .s_o (sum_o[i]),
      .c_o (c[i+1])
    );
  end

  assign co_o = c[N];

endmodule

// File: rtl/acc_word_reg.sv
module acc_word_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  // one D flip-flop per bit; clear over enable
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o[i] <= 1'b0;
      else if (clr_i)  q_o[i] <= 1'b0;
      else if (en_i)   q_o[i] <= d_i[i];
    end
  end

endmodule

// File: rtl/acc_adder_core.sv
module acc_adder_core
  import acc_adder_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic         transfer_i,
  input  logic [N-1:0] data_i,
  output logic [N-1:0] acc_o,
  output logic         carry_o
);

  localparam int unsigned AccW = N + 1;

  strobe_t         stb;
  logic [N-1:0]    b_q;
  logic [N-1:0]    sum;
  logic            co;
  logic [AccW-1:0] acc_q;

  assign stb = '{clr: clear_i, load: load_i, xfer: transfer_i};

  acc_word_reg #(.W(N)) u_b_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (1'b0),
    .en_i   (stb.load),
    .d_i    (data_i),
    .q_o    (b_q)
  );

  acc_ripple_adder #(.N(N)) u_adder (
    .a_i   (acc_q[N-1:0]),
    .b_i   (b_q),
    .sum_o (sum),
    .co_o  (co)
  );

  // carry flag stored as top bit of accumulator word
  acc_word_reg #(.W(AccW)) u_a_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (stb.clr),
    .en_i   (stb.xfer),
    .d_i    ({co, sum}),
    .q_o    (acc_q)
  );

  assign acc_o   = acc_q[N-1:0];
  assign carry_o = acc_q[N];

endmodule

// File: rtl/acc_adder_checker.sv
module acc_adder_checker #(
  parameter int unsigned N = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clear_i,
  input logic         load_i,
  input logic         transfer_i,
  input logic [N-1:0] data_i,
  input logic [N-1:0] acc_o,
  input logic         carry_o
);

  logic [N-1:0] shadow_b;
  logic [N:0]   sum_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_b <= '0;
    else if (load_i) shadow_b <= data_i;
  end

  assign sum_w = {1'b0, acc_o} + {1'b0, shadow_b};

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_zero: assert (acc_o == '0 && carry_o == 1'b0)
        else $error("R1 accumulator not zero in reset");
    end
  end

  a_r2_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (acc_o == '0 && carry_o == 1'b0));

  a_r4_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (transfer_i && !clear_i) |=> acc_o == $past(sum_w[N-1:0]));

  a_r5_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (transfer_i && !clear_i) |=> carry_o == $past(sum_w[N]));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!transfer_i && !clear_i) |=> ($stable(acc_o) && $stable(carry_o)));

  a_r7_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && transfer_i) |=> (acc_o == '0 && !carry_o));

endmodule

bind acc_adder_core acc_adder_checker #(.N(N)) i_chk (.*);

// File: tb/test_acc_adder_core.sv
`timescale 1ns/1ps
module test_acc_adder_core;

  localparam int N    = 4;
  localparam int MASK = (1 << N) - 1;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         clear_i = 1'b0;
  logic         load_i = 1'b0;
  logic         transfer_i = 1'b0;
  logic [N-1:0] data_i = '0;
  logic [N-1:0] acc_o;
  logic         carry_o;

  int tests = 0;
  int fails = 0;
  int ref_a = 0;
  int ref_b = 0;
  int ref_c = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  acc_adder_core #(.N(N)) i_acc_adder_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .load_i     (load_i),
    .transfer_i (transfer_i),
    .data_i     (data_i),
    .acc_o      (acc_o),
    .carry_o    (carry_o)
  );

  task automatic check(input string tag);
    tests++;
    if (acc_o !== ref_a[N-1:0] || carry_o !== ref_c[0]) begin
      fails++;
      $display("FAIL %s: acc=%0h carry=%0b expected acc=%0h carry=%0b",
               tag, acc_o, carry_o, ref_a[N-1:0], ref_c[0]);
    end
  endtask

  // drive at negedge, model the edge, compare 1 ns after it
  task automatic step(input bit clr, input bit ld, input bit xf,
                      input int d, input string tag);
    int s;
    @(negedge clk_i);
    clear_i = clr; load_i = ld; transfer_i = xf; data_i = d[N-1:0];
    @(posedge clk_i);
    if (clr) begin
      ref_a = 0; ref_c = 0;
    end else if (xf) begin
      s = ref_a + ref_b;
      ref_a = s & MASK;
      ref_c = (s >> N) & 1;
    end
    if (ld) ref_b = d & MASK;
    #1;
    check(tag);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    check("R1 reset state");
    rst_ni = 1'b1;
    step(0, 0, 1, 0, "R1 operand zero after reset");
    // R9 worked sequence
    step(1, 0, 0, 0, "R2 clear");
    step(0, 1, 0, 9, "R3 load 1001");
    step(0, 0, 1, 0, "R9 first transfer 1001");
    step(0, 1, 0, 5, "R3 load 0101");
    step(0, 0, 1, 0, "R9 second transfer 1110");
    step(0, 0, 0, 3, "R6 idle hold");
    step(0, 1, 0, 15, "R3 load without transfer");
    step(0, 0, 1, 0, "R5 overflow carry set");
    step(0, 0, 0, 0, "R6 carry held");
    step(0, 0, 1, 0, "R4 repeat transfer");
    step(1, 0, 0, 0, "R2 clear after carry");
    step(0, 0, 1, 0, "R4 add to cleared");
    step(1, 0, 1, 0, "R7 clear beats transfer");
    step(0, 1, 1, 3, "R8 load and transfer same edge");
    step(0, 0, 1, 0, "R8 new operand used next");
    step(1, 1, 1, 7, "R7 all strobes");
    step(0, 0, 1, 0, "R8 operand from all-strobe edge");
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom;
      step(r[0] & r[1] & r[2], r[3], r[4] | r[5], r[11:8], "R4 R5 random");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: all requirements, acc=%0h expected completion", acc_o);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule